// File: doc/BRIEF.md
# Dual-Bank Modular Micro-Op Unit

This block keeps a small set of prime-field operands and does arithmetic on them for elliptic curve point routines. The operands sit in two banks, LO (bank code 0) and HI (bank code 1). Each bank has `SLOTS` slots, and each slot holds a residue modulo the prime parameter `P_MOD`. A sequencer sends one micro-operation at a time over a valid/ready command port. An arithmetic operation reads both operands from one bank and writes its result to the same-numbered destination slot field of the other bank. Because of this, a program alternates banks and uses explicit cross-bank copies when it needs to bring a value back.

Other operations copy a slot into the opposite bank, or test a slot against zero and latch the outcome in one of `FLAGS` flag registers, where a later branch decision can read it. A host port writes operands into any slot. A separate combinational read port lets the host read any slot. Zero, one and the field inverse of two are present in both banks from reset. The modulus is a small parameter so the arithmetic can be checked over many operand pairs.

Top module: `modq_uop_unit`

## Requirements
- R1: After reset, slot 0 of each bank holds 0, slot 1 holds 1 and slot 2 holds (P_MOD+1)/2, the inverse of two. All flags are 0 and busy_o and done_o are low.
- R2: When ld_en_i is high at a clock edge, ld_data_i is written into slot ld_slot_i of bank ld_bank_i (0 = LO, 1 = HI). st_data_o shows the content of slot st_slot_i of bank st_bank_i combinationally.
- R3: Opcode 2 (add) writes (a+b) mod P_MOD into slot cmd_d_i of the bank opposite cmd_bank_i. Here a and b are slots cmd_a_i and cmd_b_i of bank cmd_bank_i. done_o is high in the cycle right after acceptance. The source bank is not written.
- R4: Opcode 3 (subtract) writes (a-b) mod P_MOD, adding the modulus back when a < b. The result is always in 0..P_MOD-1.
- R5: Opcode 1 (multiply) writes (a*b) mod P_MOD. busy_o is high for OPW cycles after acceptance, where OPW = ceil(log2(P_MOD)). The result is written at the last of these edges, and done_o is high in the cycle that follows, OPW cycles after the accepting edge.
- R6: Opcode 4 (move) copies slot cmd_a_i of bank cmd_bank_i into slot cmd_d_i of the other bank. done_o is high in the next cycle.
- R7: Opcode 5 (compare to zero) sets flag zf_o[cmd_d_i mod FLAGS] to 1 if slot cmd_a_i of bank cmd_bank_i is 0, and to 0 otherwise. The flag keeps that value until the next compare that targets the same flag. No other command changes any flag.
- R8: cmd_ready_o is low while busy_o is high. A command offered during that time waits and executes only after the multiply has written its result.
- R9: Opcodes 0, 6 and 7 write no slot and no flag and raise no done_o.
- R10: If a load and a command result target the same bank and slot at the same edge, the command result is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command accepted at this edge if valid |
| cmd_op_i | input | 3 | Opcode (1 mul, 2 add, 3 sub, 4 move, 5 compare) |
| cmd_bank_i | input | 1 | Source bank (0 LO, 1 HI) |
| cmd_a_i | input | SLW | First source slot |
| cmd_b_i | input | SLW | Second source slot |
| cmd_d_i | input | SLW | Destination slot, or flag index for compare |
| ld_en_i | input | 1 | Host load strobe |
| ld_bank_i | input | 1 | Load bank |
| ld_slot_i | input | SLW | Load slot |
| ld_data_i | input | OPW | Load value |
| st_bank_i | input | 1 | Store read bank |
| st_slot_i | input | SLW | Store read slot |
| st_data_o | output | OPW | Store read value |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | Previous cycle completed a command |
| zf_o | output | FLAGS | Latched zero flags |

## Verification
The assertions take for granted that every loaded value is a residue below P_MOD and that every slot index is below SLOTS. Under those conditions, the range of st_data_o and the correctness of the arithmetic follow. The stimulus loads values drawn only from 0..P_MOD-1 and picks all slot indices inside the slot count. Commands, including randomly mixed ones, are otherwise unconstrained. Commands may be offered during a multiply, so the hold-off path is exercised.

// File: rtl/modq_uop_pkg.sv
package modq_uop_pkg;
  typedef enum logic [2:0] {
    UOP_NOP  = 3'd0,
    UOP_MUL  = 3'd1,
    UOP_ADD  = 3'd2,
    UOP_SUB  = 3'd3,
    UOP_MOVE = 3'd4,
    UOP_CMPZ = 3'd5
  } uop_e;

  localparam int unsigned SLOT_ZERO = 0;
  localparam int unsigned SLOT_ONE  = 1;
  localparam int unsigned SLOT_HALF = 2;
endpackage

// File: rtl/modq_uop_banks.sv
module modq_uop_banks #(
  parameter int unsigned P_MOD = 251,
  parameter int unsigned SLOTS = 16,
  parameter int unsigned OPW   = 8,
  parameter int unsigned SLW   = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic           wr_bank_i,
  input  logic [SLW-1:0] wr_slot_i,
  input  logic [OPW-1:0] wr_data_i,
  input  logic           ld_en_i,
  input  logic           ld_bank_i,
  input  logic [SLW-1:0] ld_slot_i,
  input  logic [OPW-1:0] ld_data_i,
  input  logic           rd_bank_i,
  input  logic [SLW-1:0] rd_a_slot_i,
  input  logic [SLW-1:0] rd_b_slot_i,
  output logic [OPW-1:0] rd_a_o,
  output logic [OPW-1:0] rd_b_o,
  input  logic           st_bank_i,
  input  logic [SLW-1:0] st_slot_i,
  output logic [OPW-1:0] st_data_o
);
  import modq_uop_pkg::*;

  localparam logic [OPW-1:0] HALF = OPW'((P_MOD + 1) / 2);

  logic [OPW-1:0] mem_q [2][SLOTS];

  function automatic logic [OPW-1:0] init_val(input int unsigned s);
    if (s == SLOT_ONE)       return OPW'(1);
    else if (s == SLOT_HALF) return HALF;
    else                     return '0;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < SLOTS; s++)
          mem_q[b][s] <= init_val(s);
    end else begin
      if (ld_en_i) mem_q[ld_bank_i][ld_slot_i] <= ld_data_i;
      // result write placed last: wins a same-slot collision
      if (wr_en_i) mem_q[wr_bank_i][wr_slot_i] <= wr_data_i;
    end
  end

  assign rd_a_o    = mem_q[rd_bank_i][rd_a_slot_i];
  assign rd_b_o    = mem_q[rd_bank_i][rd_b_slot_i];
  assign st_data_o = mem_q[st_bank_i][st_slot_i];
endmodule

// File: rtl/modq_uop_addsub.sv
module modq_uop_addsub #(
  parameter int unsigned P_MOD = 251,
  parameter int unsigned OPW   = 8
) (
  input  logic [OPW-1:0] a_i,
  input  logic [OPW-1:0] b_i,
  input  logic           sub_i,
  output logic [OPW-1:0] y_o
);
  localparam logic [OPW:0] PM = (OPW+1)'(P_MOD);

  logic [OPW:0] sum, dif;

  always_comb begin
    sum = {1'b0, a_i} + {1'b0, b_i};
    if (sum >= PM) sum = sum - PM;
    if (a_i >= b_i) dif = {1'b0, a_i} - {1'b0, b_i};
    else            dif = {1'b0, a_i} + PM - {1'b0, b_i};
    y_o = sub_i ? dif[OPW-1:0] : sum[OPW-1:0];
  end
endmodule

// File: rtl/modq_uop_mul.sv
module modq_uop_mul #(
  parameter int unsigned P_MOD = 251,
  parameter int unsigned OPW   = 8,
  parameter int unsigned SLW   = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [OPW-1:0] a_i,
  input  logic [OPW-1:0] b_i,
  input  logic [SLW-1:0] slot_i,
  input  logic           bank_i,
  output logic           busy_o,
  output logic           wr_o,
  output logic [SLW-1:0] wr_slot_o,
  output logic           wr_bank_o,
  output logic [OPW-1:0] res_o
);
  localparam int unsigned CW = (OPW > 1) ? $clog2(OPW) : 1;
  localparam logic [OPW:0] PM = (OPW+1)'(P_MOD);

  logic           busy_q, bank_q;
  logic [CW-1:0]  cnt_q;
  logic [OPW-1:0] a_q, b_q, acc_q, nxt;
  logic [SLW-1:0] slot_q;
  logic [OPW:0]   dbl, add;

  // MSB-first double-and-add, reduced each step
  always_comb begin
    dbl = {acc_q, 1'b0};
    if (dbl >= PM) dbl = dbl - PM;
    add = dbl + {1'b0, (b_q[OPW-1] ? a_q : '0)};
    if (add >= PM) add = add - PM;
    nxt = add[OPW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      bank_q <= 1'b0;
      cnt_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      acc_q  <= '0;
      slot_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      a_q    <= a_i;
      b_q    <= b_i;
      acc_q  <= '0;
      cnt_q  <= CW'(OPW - 1);
      slot_q <= slot_i;
      bank_q <= bank_i;
    end else if (busy_q) begin
      acc_q <= nxt;
      b_q   <= b_q << 1;
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == '0) busy_q <= 1'b0;
    end
  end

  assign busy_o    = busy_q;
  assign wr_o      = busy_q && (cnt_q == '0);
  assign wr_slot_o = slot_q;
  assign wr_bank_o = bank_q;
  assign res_o     = nxt;
endmodule

// File: rtl/modq_uop_unit.sv
module modq_uop_unit #(
  parameter int unsigned P_MOD = 251,
  parameter int unsigned SLOTS = 16,
  parameter int unsigned FLAGS = 4,
  parameter int unsigned OPW   = $clog2(P_MOD),
  parameter int unsigned SLW   = $clog2(SLOTS),
  parameter int unsigned FW    = (FLAGS > 1) ? $clog2(FLAGS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [2:0]       cmd_op_i,
  input  logic             cmd_bank_i,
  input  logic [SLW-1:0]   cmd_a_i,
  input  logic [SLW-1:0]   cmd_b_i,
  input  logic [SLW-1:0]   cmd_d_i,
  input  logic             ld_en_i,
  input  logic             ld_bank_i,
  input  logic [SLW-1:0]   ld_slot_i,
  input  logic [OPW-1:0]   ld_data_i,
  input  logic             st_bank_i,
  input  logic [SLW-1:0]   st_slot_i,
  output logic [OPW-1:0]   st_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [FLAGS-1:0] zf_o
);
  import modq_uop_pkg::*;

  uop_e           op;
  logic           accept, is_alu, is_move, is_cmpz, is_mul;
  logic [OPW-1:0] rd_a, rd_b, alu_y, mul_res;
  logic           mul_busy, mul_wr, mul_bank;
  logic [SLW-1:0] mul_slot;
  logic           wr_en, wr_bank;
  logic [SLW-1:0] wr_slot;
  logic [OPW-1:0] wr_data;
  logic           done_q;

  assign op          = uop_e'(cmd_op_i);
  assign cmd_ready_o = !mul_busy;
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign is_alu      = accept && (op == UOP_ADD || op == UOP_SUB);
  assign is_move     = accept && (op == UOP_MOVE);
  assign is_cmpz     = accept && (op == UOP_CMPZ);
  assign is_mul      = accept && (op == UOP_MUL);

  modq_uop_banks #(.P_MOD(P_MOD), .SLOTS(SLOTS), .OPW(OPW), .SLW(SLW)) u_banks (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_bank_i  (wr_bank),
    .wr_slot_i  (wr_slot),
    .wr_data_i  (wr_data),
    .ld_en_i    (ld_en_i),
    .ld_bank_i  (ld_bank_i),
    .ld_slot_i  (ld_slot_i),
    .ld_data_i  (ld_data_i),
    .rd_bank_i  (cmd_bank_i),
    .rd_a_slot_i(cmd_a_i),
    .rd_b_slot_i(cmd_b_i),
    .rd_a_o     (rd_a),
    .rd_b_o     (rd_b),
    .st_bank_i  (st_bank_i),
    .st_slot_i  (st_slot_i),
    .st_data_o  (st_data_o)
  );

  modq_uop_addsub #(.P_MOD(P_MOD), .OPW(OPW)) u_addsub (
    .a_i  (rd_a),
    .b_i  (rd_b),
    .sub_i(op == UOP_SUB),
    .y_o  (alu_y)
  );

  modq_uop_mul #(.P_MOD(P_MOD), .OPW(OPW), .SLW(SLW)) u_mul (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (is_mul),
    .a_i      (rd_a),
    .b_i      (rd_b),
    .slot_i   (cmd_d_i),
    .bank_i   (!cmd_bank_i),
    .busy_o   (mul_busy),
    .wr_o     (mul_wr),
    .wr_slot_o(mul_slot),
    .wr_bank_o(mul_bank),
    .res_o    (mul_res)
  );

  // single result port; mul write and new command never coincide
  always_comb begin
    wr_en   = mul_wr || is_alu || is_move;
    wr_bank = mul_wr ? mul_bank : !cmd_bank_i;
    wr_slot = mul_wr ? mul_slot : cmd_d_i;
    wr_data = mul_wr ? mul_res : (is_move ? rd_a : alu_y);
  end

  for (genvar f = 0; f < FLAGS; f++) begin : g_flag
    logic zf_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) zf_q <= 1'b0;
      else if (is_cmpz && cmd_d_i[FW-1:0] == FW'(f)) zf_q <= (rd_a == '0);
    end
    assign zf_o[f] = zf_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= mul_wr || is_alu || is_move || is_cmpz;
  end

  assign busy_o = mul_busy;
  assign done_o = done_q;
endmodule

// File: rtl/modq_uop_unit_chk.sv
module modq_uop_unit_chk #(
  parameter int unsigned P_MOD = 251,
  parameter int unsigned OPW   = 8,
  parameter int unsigned FLAGS = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic             cmd_ready_o,
  input logic [2:0]       cmd_op_i,
  input logic [OPW-1:0]   st_data_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [FLAGS-1:0] zf_o
);
  logic acc;
  assign acc = cmd_valid_i && cmd_ready_o;

  a_r5_mul_goes_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_op_i == 3'd1) |=> busy_o);

  a_r5_done_at_mul_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r3_one_cycle_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_op_i >= 3'd2 && cmd_op_i <= 3'd5) |=> (done_o && !busy_o));

  a_r9_no_done_unknown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (cmd_op_i == 3'd0 || cmd_op_i >= 3'd6)) |=> !done_o);

  a_r7_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc && cmd_op_i == 3'd5) |=> $stable(zf_o));

  a_r4_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(st_data_o) < P_MOD);
endmodule

bind modq_uop_unit modq_uop_unit_chk #(.P_MOD(P_MOD), .OPW(OPW), .FLAGS(FLAGS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_ready_o(cmd_ready_o),
  .cmd_op_i   (cmd_op_i),
  .st_data_o  (st_data_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .zf_o       (zf_o)
);

// File: tb/modq_uop_unit_tb.sv
`timescale 1ns/1ps
module modq_uop_unit_tb;
  localparam int P = 251, N = 16, F = 4, W = 8, SW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          cmd_valid = 0, cmd_ready, cmd_bank = 0, ld_en = 0, ld_bank = 0;
  logic          st_bank = 0, busy, done;
  logic [2:0]    cmd_op = 0;
  logic [SW-1:0] cmd_a = 0, cmd_b = 0, cmd_d = 0, ld_slot = 0, st_slot = 0;
  logic [W-1:0]  ld_data = 0, st_data;
  logic [F-1:0]  zf;

  modq_uop_unit #(.P_MOD(P), .SLOTS(N), .FLAGS(F)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_bank_i(cmd_bank), .cmd_a_i(cmd_a), .cmd_b_i(cmd_b),
    .cmd_d_i(cmd_d), .ld_en_i(ld_en), .ld_bank_i(ld_bank), .ld_slot_i(ld_slot),
    .ld_data_i(ld_data), .st_bank_i(st_bank), .st_slot_i(st_slot), .st_data_o(st_data),
    .busy_o(busy), .done_o(done), .zf_o(zf)
  );

  int checks = 0, errors = 0;
  int mdl [2][N];
  logic [F-1:0] fmdl = '0;

  typedef struct { int kind; int bank; int slot; int val; int req; } exp_t;
  exp_t q[$];
  exp_t e;

  task automatic chk(input bit ok, input int req, input int act, input int expv, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // monitor: pops expected results as done_o reports them
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) chk(1'b0, 9, 1, 0, "done with nothing pending");  // R9
      else begin
        e = q.pop_front();
        if (e.kind == 0) begin
          st_bank = e.bank[0]; st_slot = SW'(e.slot);
          #1 chk(int'(st_data) == e.val, e.req, int'(st_data), e.val, "slot result");
        end else
          chk(int'(zf) == e.val, e.req, int'(zf), e.val, "flag vector");
      end
    end
  end

  task automatic load(input int b, input int s, input int v);
    @(negedge clk);
    ld_en = 1; ld_bank = b[0]; ld_slot = SW'(s); ld_data = W'(v);
    @(negedge clk);
    ld_en = 0;
    mdl[b][s] = v;
  endtask

  task automatic issue(input int op, input int b, input int a, input int bb, input int d);
    @(negedge clk);
    cmd_op = 3'(op); cmd_bank = b[0]; cmd_a = SW'(a); cmd_b = SW'(bb); cmd_d = SW'(d);
    cmd_valid = 1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic push_expect(input int op, input int b, input int a, input int bb, input int d, input int req);
    int x, y, v;
    exp_t it;
    x = mdl[b][a]; y = mdl[b][bb];
    case (op)
      1: v = (x * y) % P;
      2: v = (x + y) % P;
      3: v = ((x - y) % P + P) % P;
      4: v = x;
      default: v = 0;
    endcase
    if (op >= 1 && op <= 4) begin
      it = '{0, 1 - b, d, v, req};
      q.push_back(it);
      mdl[1 - b][d] = v;
    end else if (op == 5) begin
      fmdl[d % F] = (x == 0);
      it = '{1, 0, 0, int'(fmdl), req};
      q.push_back(it);
    end
  endtask

  task automatic do_op(input int op, input int b, input int a, input int bb, input int d, input int req);
    push_expect(op, b, a, bb, d, req);
    issue(op, b, a, bb, d);
  endtask

  task automatic drain();
    wait (q.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic peek(input int b, input int s, input int req);
    @(negedge clk);
    st_bank = b[0]; st_slot = SW'(s);
    #1 chk(int'(st_data) == mdl[b][s], req, int'(st_data), mdl[b][s], $sformatf("bank %0d slot %0d", b, s));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < N; s++)
        mdl[b][s] = (s == 1) ? 1 : (s == 2) ? (P + 1) / 2 : 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && cmd_ready, 1, {busy, done}, 0, "busy/done in reset");
    rst_n = 1;
    chk(zf == '0, 1, int'(zf), 0, "flags after reset");
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 3; s++) peek(b, s, 1);

    // R2 load and store read-back
    for (int s = 3; s < 11; s++) begin
      load(0, s, (s * 37 + 5) % P);
      load(1, s, (s * 91 + 13) % P);
    end
    load(0, 10, P - 1); load(0, 9, 200);
    for (int s = 3; s < 11; s++) begin peek(0, s, 2); peek(1, s, 2); end

    // R3 add, including wrap past the modulus
    do_op(2, 0, 3, 4, 11, 3);
    do_op(2, 0, 10, 9, 12, 3);
    do_op(2, 1, 5, 6, 11, 3);
    drain();
    peek(0, 12, 3);  // source bank slot untouched

    // R4 subtract, a<b wrap and a==b
    load(0, 5, 7); load(0, 6, 200);
    do_op(3, 0, 5, 6, 13, 4);
    do_op(3, 0, 6, 6, 14, 4);
    do_op(3, 1, 7, 8, 13, 4);

    // R6 move both directions
    do_op(4, 0, 3, 3, 15, 6);
    do_op(4, 1, 4, 4, 15, 6);
    drain();

    // R5 latency: done OPW cycles after the accepting edge
    begin
      int k;
      push_expect(1, 0, 10, 9, 3, 5);
      issue(1, 0, 10, 9, 3);
      k = 0;
      while (!done && k < 40) begin @(negedge clk); k++; end
      chk(k == W, 5, k, W, "multiply latency");
    end
    drain();
    do_op(1, 0, 3, 0, 4, 5);   // times zero
    do_op(1, 0, 4, 1, 5, 5);   // times one
    do_op(1, 1, 7, 2, 6, 5);   // times inverse of two

    // R8 hold-off: add depends on the multiply result
    do_op(1, 0, 7, 8, 13, 8);
    chk(busy && !cmd_ready, 8, {busy, cmd_ready}, 2, "busy with ready low");
    do_op(2, 1, 13, 1, 13, 8);
    drain();

    // R7 compare to zero into several flags
    do_op(5, 0, 0, 0, 2, 7);
    do_op(5, 1, 3, 0, 0, 7);
    do_op(5, 1, 0, 0, 7, 7);   // index 7 -> flag 3
    do_op(2, 0, 3, 4, 8, 7);
    drain();
    chk(zf == fmdl, 7, int'(zf), int'(fmdl), "flags persist");

    // R9 unknown opcodes leave state alone
    issue(6, 0, 3, 4, 14);
    issue(0, 1, 3, 4, 14);
    issue(7, 0, 3, 4, 14);
    drain();
    peek(1, 14, 9); peek(0, 14, 9);
    chk(zf == fmdl, 9, int'(zf), int'(fmdl), "flags after unknown op");

    // R10 collision of load and result write
    begin
      exp_t it;
      int v;
      v = (mdl[0][3] + mdl[0][4]) % P;
      it = '{0, 1, 5, v, 10};
      q.push_back(it);
      @(negedge clk);
      cmd_op = 3'd2; cmd_bank = 0; cmd_a = 3; cmd_b = 4; cmd_d = 5; cmd_valid = 1;
      ld_en = 1; ld_bank = 1; ld_slot = 5; ld_data = 8'd77;
      @(negedge clk);
      cmd_valid = 0; ld_en = 0;
      mdl[1][5] = v;
      drain();
      peek(1, 5, 10);
    end

    // mixed random program, R3 R4 R5 R6 R7
    for (int i = 0; i < 80; i++) begin
      int op, b;
      op = int'($urandom_range(1, 5));
      b  = int'($urandom_range(0, 1));
      do_op(op, b, int'($urandom_range(0, N - 1)), int'($urandom_range(0, N - 1)),
            int'($urandom_range(3, N - 1)), op == 1 ? 5 : op == 2 ? 3 : op == 3 ? 4 : op == 4 ? 6 : 7);
    end
    drain();
    for (int s = 0; s < N; s++) begin peek(0, s, 2); peek(1, s, 2); end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule